// File: doc/BRIEF.md
# Lane-Replicated Store RAM Slave

This block is a Wishbone classic slave that fronts a 32-bit synchronous RAM on a word-aligned bus. A master that stores a byte or a halfword copies that value across every lane of the write data (a byte four times, a halfword twice). It then marks with the select bits the lanes that are to be written. The slave commits only the selected bytes at the word address, so no data shifting takes place on the store path. Loads always return the whole word.

A separate load formatter takes the returned word and extracts the requested byte or halfword lane. The lane comes from a byte offset. The formatter then zero-extends or sign-extends the value. An alignment input can force the offset to zero.

The bus handshake uses the usual Wishbone hold-until-acknowledge rule for back-pressure. The master raises cycle and strobe together and holds them, with the address, data and selects, until it sees acknowledge. The slave never stalls longer than one cycle. After acknowledge the master may drop the request, or keep it raised to start the next access.

Top module: `lane_store_ram_slave`

## Requirements
- R1: A synchronous active-high reset clears acknowledge. When cycle and strobe are not both high at a clock edge, acknowledge is low in the following cycle.
- R2: When cycle and strobe are both high at a clock edge and acknowledge is low, acknowledge is high for exactly the next cycle. Read data is valid in that acknowledge cycle and holds until the next read.
- R3: A write (write-enable high) updates byte lane b (data bits 8b+7..8b) only when select bit b is 1. Bytes with a select bit of 0 keep their contents.
- R4: A read (write-enable low) never changes the memory, whatever the select bits are, and it returns the full 32-bit word regardless of the select bits.
- R5: The word is addressed by byte-address bits 11..2, giving 1024 distinct words. The lowest and the highest word do not alias.
- R6: Formatter kind 1 returns the byte at lane offset[1:0] zero-extended. Kind 2 returns the same byte sign-extended from its bit 7.
- R7: Formatter kind 3 returns the halfword selected by offset bit 1 (0 = bits 15..0, 1 = bits 31..16) zero-extended. Kind 4 returns it sign-extended from its bit 15.
- R8: Formatter kind 0, and the unused codes 5, 6 and 7, return the word unchanged.
- R9: When the align input is high, the formatter treats the offset as 0.
- R10: A byte store carrying the byte in all four lanes with select one-hot at its offset (offset 1 gives 0010), or a halfword store carrying the halfword in both halves with select 0011 (offset bit 1 = 0) or 1100 (offset bit 1 = 1), reads back through the formatter as the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Access strobe |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | 10 | Word address (byte-address bits 11..2) |
| wb_sel_i | input | 4 | Byte-lane write selects |
| wb_dat_i | input | 32 | Lane-replicated write data |
| wb_dat_o | output | 32 | Full read word |
| wb_ack_o | output | 1 | Single-cycle acknowledge |
| fmt_kind_i | input | 3 | Load kind: 0 word, 1 ubyte, 2 sbyte, 3 uhalf, 4 shalf |
| fmt_off_i | input | 2 | Byte offset of the load |
| fmt_align_i | input | 1 | Force offset to zero |
| ld_data_o | output | 32 | Extracted and extended load value |

## Verification
The bench first fills sixteen words, spread across both ends of the address range, with full-word writes. Reading these back separates correct word addressing from aliasing. It then stores a byte at each of the four offsets and a halfword at each half of every word, with the value replicated and one-hot or paired selects. A re-read of the whole word shows whether the untouched lanes kept their contents. Reads with sparse selects and writes with write-enable low are compared against an arithmetic model, which shows whether the selects leak into the read path. For every word the formatter is swept over all eight kinds, four offsets and both align settings. The stored bytes have the top bit set in some lanes and clear in others, so sign extension and zero extension give different results.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 4;
  localparam int DATA_W = LANE_W * LANES;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [2:0] {
    LD_WORD  = 3'd0,
    LD_UBYTE = 3'd1,
    LD_SBYTE = 3'd2,
    LD_UHALF = 3'd3,
    LD_SHALF = 3'd4
  } ld_kind_e;
endpackage

// File: rtl/lsr_wb_ctrl.sv
module lsr_wb_ctrl
  import lsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc,
  input  logic             stb,
  input  logic             we,
  input  logic [LANES-1:0] sel,
  output logic             ack,
  output logic             rd_en,
  output logic [LANES-1:0] lane_wr
);
  logic fire;

  // An access is taken at an edge where the request is up and no ack is pending.
  assign fire  = cyc && stb && !ack;
  assign rd_en = fire && !we;

  for (genvar b = 0; b < LANES; b++) begin : g_lane_we
    assign lane_wr[b] = fire && we && sel[b];
  end

  always_ff @(posedge clk) begin
    if (rst) ack <= 1'b0;
    else     ack <= fire;
  end
endmodule

// File: rtl/lsr_lane_ram.sv
module lsr_lane_ram
  import lsr_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic              clk,
  input  logic              wr,
  input  logic              rd,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANE_W-1:0] din,
  output logic [LANE_W-1:0] dout
);
  localparam int DEPTH = 1 << IDX_W;

  logic [LANE_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) store[idx] <= din;
    if (rd) dout <= store[idx];
  end
endmodule

// File: rtl/lsr_load_fmt.sv
module lsr_load_fmt
  import lsr_pkg::*;
(
  input  logic [DATA_W-1:0] word,
  input  logic [2:0]        kind,
  input  logic [OFF_W-1:0]  off,
  input  logic              align,
  output logic [DATA_W-1:0] q
);
  localparam int HALF_W = DATA_W / 2;

  logic [OFF_W-1:0]  eff_off;
  logic [LANE_W-1:0] byte_v;
  logic [HALF_W-1:0] half_v;

  assign eff_off = align ? '0 : off;
  assign half_v  = eff_off[OFF_W-1] ? word[DATA_W-1:HALF_W] : word[HALF_W-1:0];

  always_comb begin
    byte_v = '0;
    for (int b = 0; b < LANES; b++) begin
      if (eff_off == OFF_W'(b)) byte_v = word[b*LANE_W +: LANE_W];
    end
  end

  always_comb begin
    case (ld_kind_e'(kind))
      LD_UBYTE: q = {{(DATA_W-LANE_W){1'b0}}, byte_v};
      LD_SBYTE: q = {{(DATA_W-LANE_W){byte_v[LANE_W-1]}}, byte_v};
      LD_UHALF: q = {{(DATA_W-HALF_W){1'b0}}, half_v};
      LD_SHALF: q = {{(DATA_W-HALF_W){half_v[HALF_W-1]}}, half_v};
      default:  q = word;
    endcase
  end
endmodule

// File: rtl/lane_store_ram_slave.sv
module lane_store_ram_slave
  import lsr_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wb_cyc_i,
  input  logic                wb_stb_i,
  input  logic                wb_we_i,
  input  logic [IDX_W+1:2]    wb_adr_i,
  input  logic [LANES-1:0]    wb_sel_i,
  input  logic [DATA_W-1:0]   wb_dat_i,
  output logic [DATA_W-1:0]   wb_dat_o,
  output logic                wb_ack_o,
  input  logic [2:0]          fmt_kind_i,
  input  logic [OFF_W-1:0]    fmt_off_i,
  input  logic                fmt_align_i,
  output logic [DATA_W-1:0]   ld_data_o
);
  logic             rd_en;
  logic [LANES-1:0] lane_wr;

  lsr_wb_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cyc     (wb_cyc_i),
    .stb     (wb_stb_i),
    .we      (wb_we_i),
    .sel     (wb_sel_i),
    .ack     (wb_ack_o),
    .rd_en   (rd_en),
    .lane_wr (lane_wr)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    lsr_lane_ram #(.IDX_W(IDX_W)) u_ram (
      .clk  (clk),
      .wr   (lane_wr[b]),
      .rd   (rd_en),
      .idx  (wb_adr_i),
      .din  (wb_dat_i[b*LANE_W +: LANE_W]),
      .dout (wb_dat_o[b*LANE_W +: LANE_W])
    );
  end

  lsr_load_fmt u_fmt (
    .word  (wb_dat_o),
    .kind  (fmt_kind_i),
    .off   (fmt_off_i),
    .align (fmt_align_i),
    .q     (ld_data_o)
  );
endmodule

// File: rtl/lsr_checker.sv
module lsr_checker
  import lsr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cyc,
  input logic              stb,
  input logic              we,
  input logic              ack,
  input logic [2:0]        kind,
  input logic [DATA_W-1:0] rdat,
  input logic [DATA_W-1:0] ld
);
  logic rd_pend, rd_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend <= 1'b0;
      rd_seen <= 1'b0;
    end else begin
      rd_pend <= cyc && stb && !ack && !we;
      rd_seen <= rd_seen || rd_pend;
    end
  end

  p_reset_clears_ack_r1: assert property (@(posedge clk) rst |=> !ack);
  p_idle_no_ack_r1: assert property (@(posedge clk) disable iff (rst)
    !(cyc && stb) |=> !ack);
  p_ack_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    (cyc && stb && !ack) |=> ack);
  p_ack_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
  p_ubyte_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_seen && kind == 3'd1) |-> ld[31:8] == 24'd0);
  p_sbyte_sign_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_seen && kind == 3'd2) |->
      ($countones(ld[31:7]) == 0 || $countones(ld[31:7]) == 25));
  p_uhalf_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_seen && kind == 3'd3) |-> ld[31:16] == 16'd0);
  p_shalf_sign_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_seen && kind == 3'd4) |->
      ($countones(ld[31:15]) == 0 || $countones(ld[31:15]) == 17));
  p_word_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_seen && (kind == 3'd0 || kind >= 3'd5)) |-> ld == rdat);
endmodule

bind lane_store_ram_slave lsr_checker u_chk (
  .clk  (clk),
  .rst  (rst),
  .cyc  (wb_cyc_i),
  .stb  (wb_stb_i),
  .we   (wb_we_i),
  .ack  (wb_ack_o),
  .kind (fmt_kind_i),
  .rdat (wb_dat_o),
  .ld   (ld_data_o)
);

// File: tb/tb_lane_store_ram_slave.sv
module tb_lane_store_ram_slave;
  logic        clk = 1'b0;
  logic        rst;
  logic        cyc, stb, we;
  logic [11:2] adr;
  logic [3:0]  sel;
  logic [31:0] wdat, rdat, ld;
  logic        ack;
  logic [2:0]  kind;
  logic [1:0]  off;
  logic        align;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] model [16];

  always #2 clk = ~clk;

  lane_store_ram_slave dut (
    .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_sel_i(sel), .wb_dat_i(wdat), .wb_dat_o(rdat),
    .wb_ack_o(ack), .fmt_kind_i(kind), .fmt_off_i(off),
    .fmt_align_i(align), .ld_data_o(ld)
  );

  function automatic logic [9:0] widx(input int i);
    return (i < 8) ? 10'(i) : 10'(1016 + i - 8);
  endfunction

  function automatic logic [31:0] exp_fmt(input logic [31:0] w, input int k,
                                          input int o, input bit al);
    int e = al ? 0 : o;
    logic [7:0]  by = w[8*e +: 8];
    logic [15:0] hf = (e >= 2) ? w[31:16] : w[15:0];
    case (k)
      1: return {24'd0, by};
      2: return {{24{by[7]}}, by};
      3: return {16'd0, hf};
      4: return {{16{hf[15]}}, hf};
      default: return w;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input int i, input logic [3:0] s,
                      input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = widx(i); sel = s; wdat = d;
    @(posedge clk); #1;
    chk(ack === 1'b1, "R2 ack rises one cycle after request", 32'(ack), 32'd1);
    q = rdat;
    @(negedge clk);
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(posedge clk); #1;
    chk(ack === 1'b0, "R2 ack lasts one cycle", 32'(ack), 32'd0);
  endtask

  task automatic store(input int i, input logic [3:0] s, input logic [31:0] d);
    logic [31:0] q;
    xfer(1'b1, i, s, d, q);
    for (int b = 0; b < 4; b++)
      if (s[b]) model[i][8*b +: 8] = d[8*b +: 8];
  endtask

  task automatic check_word(input int i, input logic [3:0] s, input string tag);
    logic [31:0] q;
    xfer(1'b0, i, s, 32'hDEAD_BEEF, q);
    chk(q === model[i], tag, q, model[i]);
  endtask

  task automatic check_fmt(input int k, input int o, input bit al,
                           input string tag);
    logic [31:0] e;
    kind = 3'(k); off = 2'(o); align = al;
    #1;
    e = exp_fmt(rdat, k, o, al);
    chk(ld === e, tag, ld, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] q;
    rst = 1'b1; cyc = 1'b0; stb = 1'b0; we = 1'b0; adr = '0; sel = '0;
    wdat = '0; kind = '0; off = '0; align = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(ack === 1'b0, "R1 ack low in reset", 32'(ack), 32'd0);
    @(negedge clk); rst = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(posedge clk); #1;
      chk(ack === 1'b0, "R1 no ack while idle", 32'(ack), 32'd0);
    end

    // R5: full-word fill at both ends of the range, then read back.
    for (int i = 0; i < 16; i++) begin
      model[i] = 32'(i) * 32'h9E37_79B1 ^ 32'h5A80_7F01;
      store(i, 4'b1111, model[i]);
    end
    for (int i = 0; i < 16; i++) check_word(i, 4'b1111, "R5 word fill readback");

    // R10/R3: replicated byte stores with one-hot selects.
    for (int i = 0; i < 16; i++) begin
      for (int o = 0; o < 4; o++) begin
        logic [7:0] bv = 8'(i * 37 + o * 101 + (o[0] ? 8'h80 : 8'h00));
        store(i, 4'b0001 << o, {4{bv}});
        check_word(i, 4'b1111, "R3 byte store lanes");
        check_fmt(1, o, 1'b0, "R10 byte reload unsigned");
        chk(ld === {24'd0, bv}, "R10 byte value", ld, {24'd0, bv});
        check_fmt(2, o, 1'b0, "R10 byte reload signed");
      end
    end

    // R10/R3: replicated halfword stores, select 0011 or 1100.
    for (int i = 0; i < 16; i++) begin
      for (int h = 0; h < 2; h++) begin
        logic [15:0] hv = 16'(i * 4099 + h * 32771);
        store(i, h ? 4'b1100 : 4'b0011, {2{hv}});
        check_word(i, 4'b1111, "R3 halfword store lanes");
        check_fmt(4, 2 * h, 1'b0, "R10 halfword reload signed");
        check_fmt(3, 2 * h, 1'b0, "R10 halfword reload unsigned");
        chk(ld === {16'd0, hv}, "R10 halfword value", ld, {16'd0, hv});
      end
    end

    // R4: reads with write-enable low leave memory untouched, sparse selects.
    for (int i = 0; i < 16; i++) begin
      xfer(1'b0, i, 4'(i), 32'hFFFF_FFFF, q);
      chk(q === model[i], "R4 read ignores selects", q, model[i]);
    end
    for (int i = 0; i < 16; i++) check_word(i, 4'b0001, "R4 memory unchanged by reads");

    // R3: write with no selects changes nothing.
    store(3, 4'b0000, 32'h1234_5678);
    check_word(3, 4'b1111, "R3 zero-select write ignored");

    // R6 R7 R8 R9: formatter sweep on every word.
    for (int i = 0; i < 16; i++) begin
      check_word(i, 4'b1111, "R5 word before formatter sweep");
      for (int k = 0; k < 8; k++)
        for (int o = 0; o < 4; o++)
          for (int al = 0; al < 2; al++)
            check_fmt(k, o, al[0], (al != 0) ? "R9 align forces offset 0" :
                      (k == 1 || k == 2) ? "R6 byte extract" :
                      (k == 3 || k == 4) ? "R7 halfword extract" :
                      "R8 word passthrough");
    end

    // R1: reset mid-run clears ack.
    @(negedge clk); cyc = 1'b1; stb = 1'b1; we = 1'b0; rst = 1'b1;
    @(posedge clk); #1;
    chk(ack === 1'b0, "R1 reset overrides request", 32'(ack), 32'd0);
    @(negedge clk); cyc = 1'b0; stb = 1'b0; rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule